// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block keeps the digital state of a small bank of voltage-output converter channels. A serial receiver hands it one decoded word per strobe: an 8-bit command and a 16-bit data field. Each channel has two registers. The input register is a staging register. The DAC register holds the code the converter actually shows. Commands can stage a code, stage it and show it at once, or copy staged codes to the outputs for a chosen set of channels. An active-low load pin copies all staged codes at once. While that pin is held low, any write goes straight through to the outputs.

The block also holds a power-down flag for each channel, an enable for the ready signal used in daisy chains, and a linearity calibration bit. A software clear returns every register to its reset state. Reset, and also the software clear, set the DAC registers to zero or to midscale, as chosen by a select pin. Two parameters set the variant: `RES` gives the code width (16 or 12 bits) and `NCH` gives the channel count (4 or 2).

Top module: `dac_bank_ctrl`

## Requirements
- R1: When `rst_n` is sampled low, every input register is cleared to zero. Every DAC register becomes midscale (MSB only set, 0x8000 at 16 bits) if `mid_sel` is high, or zero if it is low. All power-down flags clear, `ready_en` goes to 1 and `lin_cal` goes to 0.
- R2: Commands 0x10 to 0x1F load the code into the input registers of the channels whose bit is set in command bits [3:0], where bit i selects channel i. With `load_n` high, the DAC registers do not change.
- R3: Commands 0x30 to 0x3F load the code into both the input and the DAC registers of the selected channels. The new code is visible on `dac_codes` one clock after the strobe.
- R4: Command 0x01 copies the input register to the DAC register for each channel i whose data bit 12+i is 1. Channels whose bit is 0 keep their code.
- R5: On every clock edge where `load_n` is low, every DAC register loads its input register. If a write command arrives in that same cycle, the channels it selects take the new code directly.
- R6: Command 0x02 restores the full reset state of R1, using the current `mid_sel`. It takes priority over `load_n` and over any other update in that cycle.
- R7: Command 0x03 sets the power-down flag of channel i from data bit 12+i and sets `ready_en` from data bit 11. DAC codes are kept. `ref_pd` is high only while every channel is powered down.
- R8: Command 0x05 sets `lin_cal` from data bit 9. All other bits of the data field are ignored.
- R9: Command 0x00, and every command code that is not listed in R2 to R8, leaves all outputs unchanged.
- R10: Codes are taken MSB-first from data bits [15:16-RES], so at 12 bits data bits [3:0] are ignored and midscale is 0x800. With two channels, command select bits 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe marking a received word |
| cmd | input | 8 | Command byte |
| data | input | 16 | Data field, MSB first |
| load_n | input | 1 | Hardware load, active low, level sensitive |
| mid_sel | input | 1 | Reset value select: 1 gives midscale, 0 gives zero |
| dac_codes | output | NCH*RES | DAC register codes; channel i sits at bits [i*RES +: RES] |
| pd_flags | output | NCH | Per-channel power-down flags |
| ref_pd | output | 1 | High when all channels are powered down |
| ready_en | output | 1 | Ready output enable |
| lin_cal | output | 1 | Linearity calibration bit |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the hardware load pin and a write command. The second pair is the load pin and a software clear. The bench holds `load_n` low across a stage-only write and checks that the written channel shows the new code while the other channels show their staged codes. It then holds `load_n` low across a clear and checks, one edge later, that the outputs show the reset value and not the old staged codes. A following software load, with the pin released, shows that the input registers were also cleared.

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl #(
  parameter int RES = 16,
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd,
  input  logic [15:0]        data,
  input  logic               load_n,
  input  logic               mid_sel,
  output logic [NCH*RES-1:0] dac_codes,
  output logic [NCH-1:0]     pd_flags,
  output logic               ref_pd,
  output logic               ready_en,
  output logic               lin_cal
);
  localparam logic [RES-1:0] MID = {1'b1, {(RES-1){1'b0}}};

  wire [RES-1:0] code    = data[15 -: RES];
  wire           is_wr   = cmd_valid && (cmd[7:4] == 4'h1 || cmd[7:4] == 4'h3);
  wire           is_thru = cmd_valid && cmd[7:4] == 4'h3;
  wire           is_ld   = cmd_valid && cmd == 8'h01;
  wire           is_clr  = (cmd_valid && cmd == 8'h02) || !rst_n;
  wire           is_pwr  = cmd_valid && cmd == 8'h03;
  wire           is_lin  = cmd_valid && cmd == 8'h05;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [RES-1:0] in_q, out_q;
    wire sel = is_wr && cmd[ch];
    wire ld  = is_ld && data[12+ch];

    always_ff @(posedge clk) begin
      if (is_clr) begin
        in_q  <= '0;
        out_q <= mid_sel ? MID : '0;
      end else begin
        if (sel) in_q <= code;
        if (sel && (is_thru || !load_n)) out_q <= code;
        else if (ld || !load_n)          out_q <= in_q;
      end
    end

    assign dac_codes[ch*RES +: RES] = out_q;
  end

  always_ff @(posedge clk) begin
    if (is_clr) begin
      pd_flags <= '0;
      ready_en <= 1'b1;
      lin_cal  <= 1'b0;
    end else begin
      if (is_pwr) begin
        pd_flags <= data[12 +: NCH];
        ready_en <= data[11];
      end
      if (is_lin) lin_cal <= data[9];
    end
  end

  assign ref_pd = &pd_flags;
endmodule

module dac_bank_ctrl_chk #(
  parameter int RES = 16,
  parameter int NCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [7:0]         cmd,
  input logic               load_n,
  input logic [NCH*RES-1:0] dac_codes,
  input logic [NCH-1:0]     pd_flags,
  input logic               ref_pd,
  input logic               ready_en,
  input logic               lin_cal
);
  a_r2_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd[7:4] == 4'h1 && load_n |=> $stable(dac_codes));

  a_r6_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == 8'h02 |=> pd_flags == '0 && !lin_cal && ready_en);

  a_r7_refpd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_pd) |-> $past(cmd_valid && cmd == 8'h03));

  a_r7_pd_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == 8'h03 && load_n |=> $stable(dac_codes));

  a_r8_lin_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lin_cal) && $past(rst_n) |-> $past(cmd_valid && (cmd == 8'h05 || cmd == 8'h02)));

  a_r9_nop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd == 8'h00 && load_n |=> $stable(dac_codes) && $stable(pd_flags)
      && $stable(lin_cal) && $stable(ready_en));
endmodule

bind dac_bank_ctrl dac_bank_ctrl_chk #(.RES(RES), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .load_n(load_n),
  .dac_codes(dac_codes), .pd_flags(pd_flags), .ref_pd(ref_pd),
  .ready_en(ready_en), .lin_cal(lin_cal)
);

// File: tb/dac_bank_ctrl_tb.sv
module dac_bank_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd = '0;
  logic [15:0] data = '0;
  logic load_n = 1'b1;
  logic mid_sel = 1'b1;

  logic [63:0] codes;
  logic [3:0]  pd;
  logic        refpd, rdy, lin;
  logic [23:0] codes12;
  logic [1:0]  pd12;
  logic        refpd12, rdy12, lin12;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dac_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .data(data),
    .load_n(load_n), .mid_sel(mid_sel), .dac_codes(codes), .pd_flags(pd),
    .ref_pd(refpd), .ready_en(rdy), .lin_cal(lin)
  );

  dac_bank_ctrl #(.RES(12), .NCH(2)) u_dut12 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .data(data),
    .load_n(load_n), .mid_sel(mid_sel), .dac_codes(codes12), .pd_flags(pd12),
    .ref_pd(refpd12), .ready_en(rdy12), .lin_cal(lin12)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [15:0] d);
    cmd = c; data = d; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset(input logic m);
    mid_sel = m; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    chk("R1 mid codes", codes, 64'h8000_8000_8000_8000);
    chk("R1 mid codes 12b", 64'(codes12), 64'h800_800);
    chk("R1 pd/ref/rdy/lin", {pd, refpd, rdy, lin}, {4'h0, 1'b0, 1'b1, 1'b0});
    send(8'h01, 16'hF000);
    chk("R1 inputs zero", codes, 64'h0);
    do_reset(1'b0);
    chk("R1 zero codes", codes, 64'h0);
  endtask

  task automatic t_stage_and_load;
    send(8'h15, 16'h1234);
    chk("R2 stage only", codes, 64'h0);
    send(8'h01, 16'h1000);
    chk("R4 load ch0", codes, 64'h0000_0000_0000_1234);
    send(8'h01, 16'h4000);
    chk("R4 load ch2", codes, 64'h0000_1234_0000_1234);
    send(8'h01, 16'h2000);
    chk("R4 ch1 unselected by write", codes, 64'h0000_1234_0000_1234);
  endtask

  task automatic t_thru;
    send(8'h3A, 16'hABCD);
    chk("R3 writethrough ch1 ch3", codes, 64'hABCD_1234_ABCD_1234);
  endtask

  task automatic t_hw_load;
    send(8'h1F, 16'h5555);
    chk("R5 staged not shown", codes, 64'hABCD_1234_ABCD_1234);
    load_n = 1'b0;
    @(posedge clk); @(negedge clk);
    load_n = 1'b1;
    chk("R5 pin loads all", codes, 64'h5555_5555_5555_5555);
    load_n = 1'b0;
    send(8'h12, 16'h7777);
    load_n = 1'b1;
    chk("R5 transparent write", codes, 64'h5555_5555_7777_5555);
  endtask

  task automatic t_power;
    send(8'h03, 16'h5000);
    chk("R7 pd mask", {pd, refpd, rdy}, {4'b0101, 1'b0, 1'b0});
    chk("R7 codes kept", codes, 64'h5555_5555_7777_5555);
    send(8'h03, 16'hF800);
    chk("R7 all down", {pd, refpd, rdy}, {4'hF, 1'b1, 1'b1});
    send(8'h03, 16'h0000);
    chk("R7 back up keeps code", {codes, pd}, {64'h5555_5555_7777_5555, 4'h0});
  endtask

  task automatic t_lin;
    send(8'h05, 16'h0200);
    chk("R8 lin set", 64'(lin), 64'h1);
    send(8'h05, 16'hFDFF);
    chk("R8 lin clear", 64'(lin), 64'h0);
  endtask

  task automatic t_nop;
    send(8'h05, 16'h0200);
    send(8'h03, 16'hA800);
    foreach (bad_codes[i]) begin
      send(bad_codes[i], 16'hFFFF);
      chk($sformatf("R9 cmd %h codes", bad_codes[i]), codes, 64'h5555_5555_7777_5555);
      chk($sformatf("R9 cmd %h flags", bad_codes[i]), {pd, rdy, lin}, {4'hA, 1'b1, 1'b1});
    end
  endtask

  logic [7:0] bad_codes [5] = '{8'h00, 8'h07, 8'h20, 8'h4F, 8'hFF};

  task automatic t_clear;
    mid_sel = 1'b1;
    load_n = 1'b0;
    send(8'h02, 16'h0000);
    load_n = 1'b1;
    chk("R6 clear beats pin", codes, 64'h8000_8000_8000_8000);
    chk("R6 flags", {pd, rdy, lin}, {4'h0, 1'b1, 1'b0});
    send(8'h01, 16'hF000);
    chk("R6 inputs cleared", codes, 64'h0);
    mid_sel = 1'b0;
    send(8'h32, 16'h9999);
    send(8'h02, 16'h0000);
    chk("R6 clear to zero", codes, 64'h0);
  endtask

  task automatic t_variant;
    do_reset(1'b1);
    send(8'h3F, 16'hABCF);
    chk("R10 12b code", 64'(codes12), 64'hABC_ABC);
    chk("R10 16b code", codes, 64'hABCF_ABCF_ABCF_ABCF);
    send(8'h3C, 16'h1111);
    chk("R10 no ch2/3 in 2ch", 64'(codes12), 64'hABC_ABC);
    send(8'h03, 16'h3000);
    chk("R10 2ch all down", {pd12, refpd12}, {2'b11, 1'b1});
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_stage_and_load();
    t_thru();
    t_hw_load();
    t_power();
    t_lin();
    t_nop();
    t_clear();
    t_variant();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule